// File: doc/BRIEF.md
# Broadcast Storm Suppression Filter

This block sits on the receive side of one switch port. It looks at each incoming frame and decides whether it may go on. It watches only broadcast frames that arrive one after another. While that run stays short, every frame is forwarded. Once the run has reached a set length, any further broadcast is marked for discard.

A run ends when a frame that is not a broadcast arrives. It also ends on a fixed time interval, set by an internal prescaler that counts system clock cycles. With the default parameters the interval is 800 ms at 25 MHz. A configuration input turns the function on or off, and it is taken only while reset is held.

The upstream classifier raises a start strobe together with a broadcast flag for each frame. One cycle later the block presents a valid strobe and the drop verdict. A saturating counter of dropped frames is also available for status.

Top module: `bcast_storm_filter`

## Requirements
- R1: While reset is held, and in the cycle after it, `decision_valid_o` and `drop_o` are 0 and `dropped_count_o` is 0.
- R2: `decision_valid_o` is 1 in exactly the cycle after a cycle with `frame_start_i` = 1, and 0 otherwise.
- R3: When enabled, the first THRESHOLD broadcast frames of a run are forwarded (`drop_o` = 0). Every further broadcast frame in that run is dropped (`drop_o` = 1).
- R4: A frame with `frame_bcast_i` = 0 is never dropped, and it ends the run: the next broadcast counts as number one.
- R5: Every PERIOD_CYCLES clock cycles, counted from reset release, the run is cleared. The clear falls on the rising edge where the number of edges since release is a multiple of PERIOD_CYCLES.
- R6: When a frame start and a periodic clear fall on the same edge, the clear is applied first, and a broadcast on that edge is counted as number one.
- R7: `enable_cfg_i` is sampled only while `rst_ni` = 0. When it was 0, no frame is ever dropped. Changing `enable_cfg_i` after reset has no effect until the next reset.
- R8: `dropped_count_o` increases by one in the same cycle that `drop_o` = 1, holds otherwise, and saturates at all ones.
- R9: `drop_o` is never 1 unless `decision_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| enable_cfg_i | input | 1 | Turns suppression on; sampled during reset |
| frame_start_i | input | 1 | One-cycle strobe at the start of a received frame |
| frame_bcast_i | input | 1 | Frame is a broadcast; qualified by frame_start_i |
| decision_valid_o | output | 1 | Verdict for the frame strobed one cycle earlier |
| drop_o | output | 1 | 1 = discard the frame, 0 = forward it |
| dropped_count_o | output | DROP_CNT_W | Saturating count of dropped frames |

## Verification
Every result of this block lands one rising edge after the stimulus. The valid strobe and the verdict follow the frame-start edge, and the drop counter moves on the same edge as a dropped verdict. The prescaler clear acts on the edge whose count since reset release reaches a multiple of the period. The bench drives inputs at the falling edge and keeps a reference model that it updates at each rising edge. It compares all three outputs at the next falling edge, so each comparison sees the state one edge after the inputs were applied. Directed runs place a broadcast exactly on a clear edge and push the drop counter past saturation. A long pseudo-random sweep then mixes broadcast, non-broadcast and idle cycles.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

    function automatic int unsigned bits_for(input int unsigned value);
        int unsigned n;
        n = 1;
        while ((1 << n) <= value) n++;
        return n;
    endfunction

endpackage

// File: rtl/bsf_prescaler.sv
module bsf_prescaler #(
    parameter int unsigned PERIOD_CYCLES = 20_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int unsigned PS_W = bsf_pkg::bits_for(PERIOD_CYCLES - 1);

    typedef struct packed {
        logic [PS_W-1:0] cnt;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic      at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt == PS_W'(PERIOD_CYCLES - 1));
        if (at_end) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = at_end;

endmodule

// File: rtl/bsf_run_tracker.sv
module bsf_run_tracker #(
    parameter int unsigned THRESHOLD = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic tick_i,
    input  logic start_i,
    input  logic bcast_i,
    output logic drop_now_o,
    output logic valid_o,
    output logic drop_o
);
    localparam int unsigned RUN_W = bsf_pkg::bits_for(THRESHOLD);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             valid;
        logic             drop;
    } run_state_t;

    run_state_t       st_d, st_q;
    logic [RUN_W-1:0] base;

    always_comb begin
        st_d       = st_q;
        st_d.valid = start_i;
        st_d.drop  = 1'b0;
        base       = tick_i ? '0 : st_q.run;
        if (!en_i) begin
            st_d.run = '0;
        end else if (start_i && bcast_i) begin
            if (base >= RUN_W'(THRESHOLD)) begin
                st_d.drop = 1'b1;
                st_d.run  = base;
            end else begin
                st_d.run  = base + 1'b1;
            end
        end else if (start_i) begin
            st_d.run = '0;
        end else begin
            st_d.run = base;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drop_now_o = st_d.drop;
    assign valid_o    = st_q.valid;
    assign drop_o     = st_q.drop;

endmodule

// File: rtl/bsf_drop_counter.sv
module bsf_drop_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } dc_state_t;

    dc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc_i && (st_q.cnt != {CNT_W{1'b1}})) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/bcast_storm_filter.sv
module bcast_storm_filter #(
    parameter int unsigned THRESHOLD     = 64,
    parameter int unsigned PERIOD_CYCLES = 20_000_000,
    parameter int unsigned DROP_CNT_W    = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  enable_cfg_i,
    input  logic                  frame_start_i,
    input  logic                  frame_bcast_i,
    output logic                  decision_valid_o,
    output logic                  drop_o,
    output logic [DROP_CNT_W-1:0] dropped_count_o
);
    typedef struct packed {
        logic en;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;
    logic       en_q;
    logic       tick;
    logic       drop_now;

    always_comb begin
        cfg_d = cfg_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q.en <= enable_cfg_i;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_q = cfg_q.en;

    bsf_prescaler #(
        .PERIOD_CYCLES(PERIOD_CYCLES)
    ) u_prescaler (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(tick)
    );

    bsf_run_tracker #(
        .THRESHOLD(THRESHOLD)
    ) u_tracker (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_q),
        .tick_i    (tick),
        .start_i   (frame_start_i),
        .bcast_i   (frame_bcast_i),
        .drop_now_o(drop_now),
        .valid_o   (decision_valid_o),
        .drop_o    (drop_o)
    );

    bsf_drop_counter #(
        .CNT_W(DROP_CNT_W)
    ) u_drop_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (drop_now),
        .count_o(dropped_count_o)
    );

endmodule

// File: rtl/bcast_storm_filter_checker.sv
module bcast_storm_filter_checker #(
    parameter int unsigned DROP_CNT_W = 16
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  en_q,
    input logic                  frame_start_i,
    input logic                  frame_bcast_i,
    input logic                  decision_valid_o,
    input logic                  drop_o,
    input logic [DROP_CNT_W-1:0] dropped_count_o
);
    logic armed_q;

    always_ff @(posedge clk_i) begin
        armed_q <= rst_ni;
    end

    AST_DROP_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        drop_o |-> decision_valid_o); // R9

    AST_VALID_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        frame_start_i |=> decision_valid_o); // R2

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        !frame_start_i |=> !decision_valid_o); // R2

    AST_NONBCAST_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        (frame_start_i && !frame_bcast_i) |=> !drop_o); // R4

    AST_DISABLED_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        !en_q |-> !drop_o); // R7

    AST_COUNT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        !drop_o |-> $stable(dropped_count_o)); // R8

    AST_COUNT_NEVER_FALLS: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
        dropped_count_o >= $past(dropped_count_o)); // R8

endmodule

bind bcast_storm_filter bcast_storm_filter_checker #(
    .DROP_CNT_W(DROP_CNT_W)
) u_checker (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .en_q            (en_q),
    .frame_start_i   (frame_start_i),
    .frame_bcast_i   (frame_bcast_i),
    .decision_valid_o(decision_valid_o),
    .drop_o          (drop_o),
    .dropped_count_o (dropped_count_o)
);

// File: tb/bcast_storm_filter_tb.sv
module bcast_storm_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TH         = 4;
    localparam int P          = 50;
    localparam int DW         = 4;
    localparam int DMAX       = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b1;
    logic          fs = 1'b0;
    logic          bc = 1'b0;
    logic          valid;
    logic          drop;
    logic [DW-1:0] dcnt;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R3";

    int m_en, m_run, m_dc, m_ecnt, e_valid, e_drop;

    bcast_storm_filter #(
        .THRESHOLD    (TH),
        .PERIOD_CYCLES(P),
        .DROP_CNT_W   (DW)
    ) u_dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .enable_cfg_i    (cfg_en),
        .frame_start_i   (fs),
        .frame_bcast_i   (bc),
        .decision_valid_o(valid),
        .drop_o          (drop),
        .dropped_count_o (dcnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model built from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = int'(cfg_en); m_run = 0; m_dc = 0; m_ecnt = 0;
            e_valid = 0; e_drop = 0;
        end else begin
            int tick, base;
            tick    = ((m_ecnt % P) == P - 1);
            base    = tick ? 0 : m_run;
            e_valid = int'(fs);
            e_drop  = 0;
            if (m_en == 0) begin
                m_run = 0;
            end else if (fs && bc) begin
                if (base >= TH) begin
                    e_drop = 1; m_run = base;
                    if (m_dc < DMAX) m_dc++;
                end else begin
                    m_run = base + 1;
                end
            end else if (fs) begin
                m_run = 0;
            end else begin
                m_run = base;
            end
            m_ecnt++;
        end
    end

    task automatic compare();
        n_vec++;
        if (int'(valid) != e_valid) begin
            n_bad++;
            $display("FAIL R2 valid: got %0d exp %0d", valid, e_valid);
        end else if (int'(drop) != e_drop) begin
            n_bad++;
            $display("FAIL %s drop: got %0d exp %0d", cur_req, drop, e_drop);
        end else if (int'(dcnt) != m_dc) begin
            n_bad++;
            $display("FAIL R8 count: got %0d exp %0d", dcnt, m_dc);
        end
    endtask

    task automatic cyc(input logic s, input logic b);
        fs = s; bc = b;
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset(input logic en);
        cfg_en = en; rst_n = 1'b0; fs = 1'b0; bc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        @(negedge clk);
        compare();
    endtask

    task automatic sweep(input int n, input int seed);
        logic [15:0] lf;
        lf = 16'(seed);
        for (int i = 0; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[0] | lf[1], lf[2] | lf[3] | lf[4]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        // R3: run lengths 1..2*TH separated by one non-broadcast (R4)
        for (int len = 1; len <= 2 * TH; len++) begin
            cur_req = "R3";
            for (int k = 0; k < len; k++) cyc(1'b1, 1'b1);
            cur_req = "R4";
            cyc(1'b1, 1'b0);
            cyc(1'b0, 1'b0);
        end
        // R5: fill, idle across a clear edge, then a broadcast passes
        cur_req = "R5";
        for (int k = 0; k < TH + 1; k++) cyc(1'b1, 1'b1);
        repeat (P) cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b1);
        if (drop !== 1'b0) begin
            n_bad++; $display("FAIL R5 drop after clear: got %0d exp 0", drop);
        end
        n_vec++;
        // R6: broadcast lands exactly on the clear edge
        cur_req = "R6";
        while ((m_ecnt % P) != P - 1 - TH) cyc(1'b0, 1'b0);
        for (int k = 0; k < TH; k++) cyc(1'b1, 1'b1);
        cyc(1'b1, 1'b1);
        if (drop !== 1'b0) begin
            n_bad++; $display("FAIL R6 drop on clear edge: got %0d exp 0", drop);
        end
        n_vec++;
        for (int k = 0; k < TH; k++) cyc(1'b1, 1'b1);
        if (drop !== 1'b1) begin
            n_bad++; $display("FAIL R6 drop after TH+1: got %0d exp 1", drop);
        end
        n_vec++;
        // R8: saturate the drop counter
        cur_req = "R8";
        for (int k = 0; k < 3 * DMAX; k++) cyc(1'b1, 1'b1);
        if (dcnt !== DW'(DMAX)) begin
            n_bad++; $display("FAIL R8 saturation: got %0d exp %0d", dcnt, DMAX);
        end
        n_vec++;
        // Near-exhaustive mixed sweep
        do_reset(1'b1);
        cur_req = "R3";
        sweep(3000, 16'hACE1);
        // R7: disabled, config toggled after reset has no effect
        do_reset(1'b0);
        cur_req = "R7";
        for (int k = 0; k < 2 * TH; k++) cyc(1'b1, 1'b1);
        cfg_en = 1'b1;
        for (int k = 0; k < 2 * TH; k++) cyc(1'b1, 1'b1);
        sweep(500, 16'h1234);
        if (dcnt !== '0) begin
            n_bad++; $display("FAIL R7 count while disabled: got %0d exp 0", dcnt);
        end
        n_vec++;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule